// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block turns three external interrupt pins into latched interrupt requests for a processor. Each pin is synchronized into the core clock domain. A programmable sense condition then decides which pin activity counts as an event. Sources 0 and 1 can react to a low level, any change, a falling edge or a rising edge. Source 2 reacts only to a rising or a falling edge.

An event sets the source's pending flag whether or not the source is enabled. A request leaves the block only when the source's enable bit is set and the global interrupt-enable input is high. Software reaches the flag, enable and sense registers over a byte-wide register bus. A flag is cleared by writing 1 to it, or through a per-source acknowledge input when the handler is serviced.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset the flag (address 0), enable (address 1), sense (address 2) and source-2 sense (address 3) registers all read 0x00, and irq_o is 0. The synchronizers start in the idle-high state, so no event is seen coming out of reset.
- R2: In the flag register, bit 6 is source 0, bit 7 is source 1 and bit 5 is source 2. The other bits read 0.
- R3: A trigger event sets the source's flag even when its enable bit is 0. In that case irq_o for the source stays 0.
- R4: For sources 0 and 1, the sense register holds a 2-bit code: bits [1:0] for source 0 and bits [3:2] for source 1. Code 00 selects low level, 01 any change, 10 a falling edge and 11 a rising edge. The flag is readable by the fourth clock edge after the pin changes. Pin activity that does not match the selected code sets nothing.
- R5: For source 2, bit 0 at address 3 selects the edge: 1 is rising and 0 is falling. A pin held low never raises a level request on source 2.
- R6: irq_o[k] is 1 only when the source is pending, its enable bit is 1 and gie_i is 1.
- R7: In the enable register, bit 7 enables source 0, bit 6 source 1 and bit 5 source 2. Reserved bits read 0, and so do sense bits [7:4] and address-3 bits [7:1].
- R8: Writing 1 to a flag bit clears it. Writing 0 leaves it unchanged.
- R9: If a trigger event and a clear land in the same clock cycle, the flag ends up set.
- R10: In low-level mode, the source's request and its flag bit follow the synchronized pin while it is low. Nothing latches, so both drop once the pin returns high.
- R11: Pulsing ack_i[k] for one cycle clears the flag of source k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_pin_i | input | 3 | Raw external interrupt pins, bit k for source k |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 3 | Per-source service acknowledge, clears the flag |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i while sel_i is 1 |
| irq_o | output | 3 | Gated interrupt requests, bit k for source k |

## Verification
The bound checker watches several rules on every cycle. A request never appears without the global enable and the source's own enable. A detected event always leaves its flag set on the next edge, even against a clear. A clear with no competing event always empties the flag, and a flag with neither event nor clear holds its value. A live low level with the source enabled always raises the request, and a request on source 2 always comes from its stored flag. Other behaviour can only be shown by the directed scenarios. These cover the mapping of sense codes to actual pin waveforms, the bit positions in the register map and the reserved bits reading 0. They also show the synchronizer latency, the level request dropping without a latch, and a write of 0 having no effect on the flags.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int N_SRC  = 3;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam logic [ADDR_W-1:0] A_FLAG   = 2'd0;
  localparam logic [ADDR_W-1:0] A_EN     = 2'd1;
  localparam logic [ADDR_W-1:0] A_SENSE  = 2'd2;
  localparam logic [ADDR_W-1:0] A_SENSE2 = 2'd3;

  function automatic int flag_pos(input int k);
    case (k)
      0:       return 6;
      1:       return 7;
      default: return 5;
    endcase
  endfunction

  function automatic int en_pos(input int k);
    case (k)
      0:       return 7;
      1:       return 6;
      default: return 5;
    endcase
  endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter bit LEVEL_OK    = 1'b1
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pin_i,
  input  sense_e sense_i,
  output logic   evt_o,
  output logic   level_o
);
  logic sync, prev_q, rise, fall, level_raw;

  eirq_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (sync)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= sync;
  end

  assign rise = sync & ~prev_q;
  assign fall = ~sync & prev_q;

  always_comb begin
    case (sense_i)
      SENSE_ANY:  evt_o = rise | fall;
      SENSE_FALL: evt_o = fall;
      SENSE_RISE: evt_o = rise;
      default:    evt_o = 1'b0;
    endcase
  end

  assign level_raw = (sense_i == SENSE_LOW) & ~sync;

  generate
    if (LEVEL_OK) begin : g_level
      assign level_o = level_raw;
    end else begin : g_edge_only
      assign level_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
  import ext_irq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic [N_SRC-1:0]  level_i,
  input  logic [N_SRC-1:0]  ack_i,
  output logic [N_SRC-1:0]  flag_o,
  output logic [N_SRC-1:0]  en_o,
  output logic [N_SRC-1:0]  clr_o,
  output sense_e            sense_o [N_SRC]
);
  logic [N_SRC-1:0]  flag_q, en_q;
  logic [3:0]        sense_q;
  logic              sense2_q;
  logic              wr;
  logic [DATA_W-1:0] flag_rd, en_rd;

  assign wr = sel_i & we_i;

  for (genvar k = 0; k < N_SRC; k++) begin : g_src
    assign clr_o[k] = (wr && addr_i == A_FLAG && wdata_i[flag_pos(k)]) | ack_i[k];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)             flag_q[k] <= 1'b0;
      else if (evt_i[k])       flag_q[k] <= 1'b1; // event beats clear
      else if (clr_o[k])       flag_q[k] <= 1'b0;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                     en_q[k] <= 1'b0;
      else if (wr && addr_i == A_EN)   en_q[k] <= wdata_i[en_pos(k)];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q  <= '0;
      sense2_q <= 1'b0;
    end else if (wr) begin
      if (addr_i == A_SENSE)  sense_q  <= wdata_i[3:0];
      if (addr_i == A_SENSE2) sense2_q <= wdata_i[0];
    end
  end

  assign sense_o[0] = sense_e'(sense_q[1:0]);
  assign sense_o[1] = sense_e'(sense_q[3:2]);
  assign sense_o[2] = sense_e'({1'b1, sense2_q});

  always_comb begin
    flag_rd = '0;
    en_rd   = '0;
    for (int k = 0; k < N_SRC; k++) begin
      flag_rd[flag_pos(k)] = flag_q[k] | level_i[k];
      en_rd[en_pos(k)]     = en_q[k];
    end
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i) begin
      case (addr_i)
        A_FLAG:   rdata_o = flag_rd;
        A_EN:     rdata_o = en_rd;
        A_SENSE:  rdata_o = {{(DATA_W-4){1'b0}}, sense_q};
        default:  rdata_o = {{(DATA_W-1){1'b0}}, sense2_q};
      endcase
    end
  end

  assign flag_o = flag_q;
  assign en_o   = en_q;
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  irq_pin_i,
  input  logic              gie_i,
  input  logic [N_SRC-1:0]  ack_i,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [N_SRC-1:0]  irq_o
);
  logic [N_SRC-1:0] evt, level, flag_q, en_q, clr;
  sense_e           sense [N_SRC];

  for (genvar k = 0; k < N_SRC; k++) begin : g_det
    eirq_detect #(
      .SYNC_STAGES(SYNC_STAGES),
      .LEVEL_OK   (k < 2)
    ) u_det (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (irq_pin_i[k]),
      .sense_i(sense[k]),
      .evt_o  (evt[k]),
      .level_o(level[k])
    );
  end

  eirq_regs u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel_i),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .rdata_o(rdata_o),
    .evt_i  (evt),
    .level_i(level),
    .ack_i  (ack_i),
    .flag_o (flag_q),
    .en_o   (en_q),
    .clr_o  (clr),
    .sense_o(sense)
  );

  assign irq_o = (flag_q | level) & en_q & {N_SRC{gie_i}};
endmodule

// File: rtl/ext_irq_sense_chk.sv
module ext_irq_sense_chk
  import ext_irq_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             gie_i,
  input logic [N_SRC-1:0] irq_o,
  input logic [N_SRC-1:0] en_q,
  input logic [N_SRC-1:0] flag_q,
  input logic [N_SRC-1:0] evt,
  input logic [N_SRC-1:0] clr,
  input logic [N_SRC-1:0] level
);
  p_req_needs_gie_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> gie_i);

  p_req_needs_en_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~en_q) == '0);

  p_src2_flag_only_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[2] |-> flag_q[2]);

  for (genvar k = 0; k < N_SRC; k++) begin : g_k
    // event always lands, also against a same-cycle clear (R9)
    p_event_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt[k] |=> flag_q[k]);

    // covers write-one clear and acknowledge (R11)
    p_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[k] && !evt[k]) |=> !flag_q[k]);

    p_flag_holds_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr[k] && !evt[k]) |=> $stable(flag_q[k]));

    p_level_req_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (level[k] && en_q[k] && gie_i) |-> irq_o[k]);
  end
endmodule

bind ext_irq_sense ext_irq_sense_chk u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .gie_i (gie_i),
  .irq_o (irq_o),
  .en_q  (en_q),
  .flag_q(flag_q),
  .evt   (evt),
  .clr   (clr),
  .level (level)
);

// File: tb/ext_irq_sense_test.sv
module ext_irq_sense_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] pin = 3'b111;
  logic       gie = 1'b0;
  logic [2:0] ack = 3'b000;
  logic       sel = 1'b0, we = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic [2:0] irq;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ext_irq_sense uut (
    .clk_i(clk), .rst_ni(rst_n), .irq_pin_i(pin), .gie_i(gie), .ack_i(ack),
    .sel_i(sel), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); sel = 0; we = 0; wdata = 8'h00;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); sel = 1; we = 0; addr = a;
    #1 d = rdata;
    sel = 0;
  endtask

  task automatic set_pin(input int k, input logic v);
    @(negedge clk); pin[k] = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d); check("R1 reg", d, 8'h00);
    end
    check("R1 irq", {5'b0, irq}, 8'h00);
  endtask

  task automatic t_disabled_fall;
    logic [7:0] d;
    wr(2'd2, 8'h02);                 // src0 falling
    set_pin(0, 1'b0);
    rd(2'd0, d); check("R3 flag src0 bit6 while disabled", d, 8'h40);
    check("R3 irq stays low", {5'b0, irq}, 8'h00);
    wr(2'd0, 8'h00);
    rd(2'd0, d); check("R8 write 0 keeps flag", d, 8'h40);
    wr(2'd0, 8'h40);
    rd(2'd0, d); check("R8 write 1 clears", d, 8'h00);
    set_pin(0, 1'b1);
    rd(2'd0, d); check("R4 falling ignores rise", d, 8'h00);
  endtask

  task automatic t_rise_src1;
    logic [7:0] d;
    wr(2'd2, 8'h0C);                 // src1 rising, src0 level
    set_pin(1, 1'b0);
    rd(2'd0, d); check("R4 rising ignores fall", d, 8'h00);
    set_pin(1, 1'b1);
    rd(2'd0, d); check("R2 flag src1 bit7", d, 8'h80);
    wr(2'd1, 8'h40);
    @(negedge clk); check("R6 no irq without gie", {5'b0, irq}, 8'h00);
    gie = 1;
    @(negedge clk); check("R6 irq src1", {5'b0, irq}, 8'h02);
    ack[1] = 1'b1;
    @(negedge clk); ack = 3'b000;
    rd(2'd0, d); check("R11 ack clears flag", d, 8'h00);
    check("R11 irq drops", {5'b0, irq}, 8'h00);
    gie = 0;
    wr(2'd1, 8'h00);
  endtask

  task automatic t_any_src0;
    logic [7:0] d;
    wr(2'd2, 8'h01);
    set_pin(0, 1'b0);
    rd(2'd0, d); check("R4 any change fall", d, 8'h40);
    wr(2'd0, 8'h40);
    set_pin(0, 1'b1);
    rd(2'd0, d); check("R4 any change rise", d, 8'h40);
    wr(2'd0, 8'h40);
  endtask

  task automatic t_src2;
    logic [7:0] d;
    wr(2'd3, 8'h01);
    set_pin(2, 1'b0);
    rd(2'd0, d); check("R5 rising ignores fall", d, 8'h00);
    set_pin(2, 1'b1);
    rd(2'd0, d); check("R5 rising flag bit5", d, 8'h20);
    wr(2'd0, 8'h20);
    wr(2'd3, 8'h00);
    set_pin(2, 1'b0);
    rd(2'd0, d); check("R5 falling flag", d, 8'h20);
    wr(2'd0, 8'h20);
    wr(2'd1, 8'h20); gie = 1;
    repeat (3) @(negedge clk);
    rd(2'd0, d); check("R5 low held, no level flag", d, 8'h00);
    check("R5 low held, no request", {5'b0, irq}, 8'h00);
    gie = 0; wr(2'd1, 8'h00);
    set_pin(2, 1'b1);
    wr(2'd0, 8'h20);
  endtask

  task automatic t_level;
    logic [7:0] d;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'h80); gie = 1;
    set_pin(0, 1'b0);
    check("R10 level request", {5'b0, irq}, 8'h01);
    rd(2'd0, d); check("R10 level flag view", d, 8'h40);
    set_pin(0, 1'b1);
    check("R10 request released", {5'b0, irq}, 8'h00);
    rd(2'd0, d); check("R10 no latch", d, 8'h00);
    gie = 0; wr(2'd1, 8'h00);
  endtask

  task automatic t_reserved;
    logic [7:0] d;
    wr(2'd1, 8'hFF); rd(2'd1, d); check("R7 enable bits", d, 8'hE0);
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hF0); rd(2'd2, d); check("R7 sense reserved", d, 8'h00);
    wr(2'd3, 8'hFE); rd(2'd3, d); check("R7 sense2 reserved", d, 8'h00);
  endtask

  task automatic t_event_wins;
    logic [7:0] d;
    wr(2'd2, 8'h02);
    @(negedge clk); pin[0] = 1'b0;
    @(posedge clk); @(posedge clk);
    wr(2'd0, 8'h40);                 // lands on the event edge
    rd(2'd0, d); check("R9 event beats clear", d, 8'h40);
    wr(2'd0, 8'h40);
    set_pin(0, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_disabled_fall();
    t_rise_src1();
    t_any_src0();
    t_src2();
    t_level();
    t_reserved();
    t_event_wins();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule